// File: doc/BRIEF.md
# Valid-Invalid Snooping Line Controller

This block keeps the coherence state of every line of a small write-through cache that does not allocate on writes and sits on a shared snooping bus. Each line has one flag: set means the local copy may be read, clear means it may not. The processor side asks for a load, a store or an evict of a line index. The block answers one cycle later with a hit indication and, when needed, a bus command (read or write) for the same index. A snoop port reports transactions that other agents put on the bus. Any foreign write to a line held here clears that line's flag, so the next local load fetches fresh data.

Data storage, tag comparison, bus arbitration and memory timing live elsewhere. The controller only decides the flag update and the bus action. When a snoop and a local request name the same line in the same cycle, the snoop takes effect first and the request is judged against the resulting state.

Top module: `vi_line_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every line flag, so the first load to any line after reset reports a miss.
- R2: A load to a clear line reports hit=0, issues a bus read (bus_cmd=0) for the same index, and sets the flag.
- R3: A load to a set line reports hit=1, issues no bus command, and leaves the flag set.
- R4: A store to a clear line reports hit=0, issues a bus write (bus_cmd=1), and leaves the flag clear.
- R5: A store to a set line reports hit=1, issues a bus write (bus_cmd=1), and leaves the flag set.
- R6: An evict reports the prior flag as hit, issues no bus command, and leaves the flag clear.
- R7: A snooped bus write (snp_cmd=1) to a line whose flag is set clears that flag.
- R8: A snooped bus read (snp_cmd=0) has no effect on any flag, a snooped bus write to a clear line has no effect, and a snoop alone produces no response and no bus command.
- R9: When a snooped write and a local request name the same line in the same cycle, the snoop is applied first and the request sees the line as clear.
- R10: A snooped write to one line and a local request to another line in the same cycle both take effect.
- R11: Responses and bus commands appear exactly one cycle after the request with bus_idx equal to the request index. No response and no bus command appear in a cycle that follows no request. Request encoding on req_op: 0 load, 1 store, 2 evict, 3 no operation.
- R12: With two controllers on one bus, after either agent stores to a line, the other agent's next load to that line reports a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_op | input | 2 | 0 load, 1 store, 2 evict, 3 no operation |
| req_idx | input | IDX_W | Line index of the request |
| snp_valid | input | 1 | Snooped foreign bus transaction present |
| snp_cmd | input | 1 | Snooped command: 0 read, 1 write |
| snp_idx | input | IDX_W | Line index of the snooped transaction |
| rsp_valid | output | 1 | Registered response for last cycle's request |
| rsp_hit | output | 1 | Line flag as seen by the request |
| bus_valid | output | 1 | Bus command required |
| bus_cmd | output | 1 | 0 bus read, 1 bus write |
| bus_idx | output | IDX_W | Line index for the bus command |

## Verification
A foreign write arriving on the snoop port and a local load or store can name the same line in the same cycle. The bench provokes this by wiring two controllers to one modelled bus and issuing the second agent's request in the very cycle the first agent's registered bus write reaches it as a snoop. The result is judged at the ports: the colliding load must miss and issue a bus read, and a colliding store must miss and leave the line clear, which a later load confirms. A snoop paired with a request to a different line is also checked, to show that both updates land.

// File: rtl/vi_pkg.sv
package vi_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_EVICT = 2'd2,
    OP_NONE  = 2'd3
  } vi_op_e;

  typedef enum logic {
    BUS_RD = 1'b0,
    BUS_WR = 1'b1
  } vi_bus_e;

endpackage

// File: rtl/vi_flag_array.sv
module vi_flag_array #(
  parameter int LINES = 16,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_flag,
  input  logic             kill,
  input  logic [IDX_W-1:0] kill_idx,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_val
);

  logic [LINES-1:0] flags;
  logic [LINES-1:0] flags_nxt;

  // Per-line next value: a local update wins because it was already
  // computed against the state with the snoop applied.
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic hit_upd;
    logic hit_kill;
    assign hit_upd  = upd_en && (upd_idx == IDX_W'(g));
    assign hit_kill = kill && (kill_idx == IDX_W'(g));
    assign flags_nxt[g] = hit_upd  ? upd_val :
                          hit_kill ? 1'b0    : flags[g];
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= flags_nxt;
  end

  assign rd_flag = flags[rd_idx];

  // R1: reset leaves every flag clear
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (flags == '0));

  // R7: a foreign write not overridden by a local update clears the line
  assert_snoop_kill_R7: assert property (@(posedge clk) disable iff (rst)
    (kill && !(upd_en && upd_idx == kill_idx)) |=> !flags[$past(kill_idx)]);

endmodule

// File: rtl/vi_snoop_filter.sv
module vi_snoop_filter
  import vi_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             snp_valid,
  input  logic             snp_cmd,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             stored_flag,
  output logic             kill,
  output logic [IDX_W-1:0] kill_idx,
  output logic             eff_flag
);

  logic same_line;

  // Only a foreign write matters; a foreign read leaves our copy intact.
  assign kill      = snp_valid && (vi_bus_e'(snp_cmd) == BUS_WR);
  assign kill_idx  = snp_idx;
  assign same_line = (snp_idx == req_idx);

  // Snoop ordered ahead of the local request on a collision.
  assign eff_flag  = stored_flag && !(kill && same_line);

endmodule

// File: rtl/vi_req_engine.sv
module vi_req_engine
  import vi_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             eff_flag,
  output logic             upd_en,
  output logic [IDX_W-1:0] upd_idx,
  output logic             upd_val,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             bus_valid,
  output logic             bus_cmd,
  output logic [IDX_W-1:0] bus_idx
);

  vi_op_e  op;
  logic    need_bus;
  vi_bus_e cmd_nxt;

  assign op      = vi_op_e'(req_op);
  assign upd_idx = req_idx;

  always_comb begin
    upd_en   = 1'b0;
    upd_val  = 1'b0;
    need_bus = 1'b0;
    cmd_nxt  = BUS_RD;
    if (req_valid) begin
      unique case (op)
        OP_LOAD: begin
          upd_en   = 1'b1;
          upd_val  = 1'b1;
          need_bus = !eff_flag;
          cmd_nxt  = BUS_RD;
        end
        OP_STORE: begin
          need_bus = 1'b1;
          cmd_nxt  = BUS_WR;
        end
        OP_EVICT: begin
          upd_en  = 1'b1;
          upd_val = 1'b0;
        end
        OP_NONE: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      bus_valid <= 1'b0;
      bus_cmd   <= 1'b0;
      bus_idx   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && eff_flag;
      bus_valid <= need_bus;
      bus_cmd   <= cmd_nxt;
      bus_idx   <= req_idx;
    end
  end

  // R2: load to a clear line misses and fetches
  assert_load_miss_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && op == OP_LOAD && !eff_flag)
      |=> (rsp_valid && !rsp_hit && bus_valid && bus_cmd == BUS_RD));

  // R3, R6: load hit and evict stay off the bus
  assert_quiet_bus_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ((op == OP_LOAD && eff_flag) || op == OP_EVICT))
      |=> (rsp_valid && !bus_valid));

  // R4, R5: every store goes out as a bus write with its index
  assert_store_write_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && op == OP_STORE)
      |=> (bus_valid && bus_cmd == BUS_WR && bus_idx == $past(req_idx)));

  // R11: nothing comes out after a cycle without a request
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !bus_valid));

endmodule

// File: rtl/vi_line_ctrl.sv
module vi_line_ctrl
  import vi_pkg::*;
#(
  parameter int LINES = 16,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             snp_valid,
  input  logic             snp_cmd,
  input  logic [IDX_W-1:0] snp_idx,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             bus_valid,
  output logic             bus_cmd,
  output logic [IDX_W-1:0] bus_idx
);

  logic             stored_flag;
  logic             eff_flag;
  logic             kill;
  logic [IDX_W-1:0] kill_idx;
  logic             upd_en;
  logic [IDX_W-1:0] upd_idx;
  logic             upd_val;

  vi_flag_array #(.LINES(LINES), .IDX_W(IDX_W)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (req_idx),
    .rd_flag  (stored_flag),
    .kill     (kill),
    .kill_idx (kill_idx),
    .upd_en   (upd_en),
    .upd_idx  (upd_idx),
    .upd_val  (upd_val)
  );

  vi_snoop_filter #(.IDX_W(IDX_W)) u_snoop (
    .snp_valid   (snp_valid),
    .snp_cmd     (snp_cmd),
    .snp_idx     (snp_idx),
    .req_idx     (req_idx),
    .stored_flag (stored_flag),
    .kill        (kill),
    .kill_idx    (kill_idx),
    .eff_flag    (eff_flag)
  );

  vi_req_engine #(.IDX_W(IDX_W)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_idx   (req_idx),
    .eff_flag  (eff_flag),
    .upd_en    (upd_en),
    .upd_idx   (upd_idx),
    .upd_val   (upd_val),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .bus_valid (bus_valid),
    .bus_cmd   (bus_cmd),
    .bus_idx   (bus_idx)
  );

  // R9: colliding foreign write makes the same-cycle load miss
  assert_snoop_first_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'd0 && snp_valid && snp_cmd && snp_idx == req_idx)
      |=> (rsp_valid && !rsp_hit && bus_valid && !bus_cmd));

  // R8: a foreign read leaves the addressed flag untouched when no local
  // request is present
  assert_snoop_read_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && !snp_cmd && !req_valid) |=> $stable(u_flags.flags));

endmodule

// File: tb/test_vi_line_ctrl.sv
module test_vi_line_ctrl;

  localparam int LINES = 16;
  localparam int IDX_W = 4;
  localparam logic [1:0] LD = 2'd0, ST = 2'd1, EV = 2'd2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic             a_req_valid = 0, b_req_valid = 0;
  logic [1:0]       a_req_op = 0, b_req_op = 0;
  logic [IDX_W-1:0] a_req_idx = 0, b_req_idx = 0;
  logic             a_rsp_valid, a_rsp_hit, a_bus_valid, a_bus_cmd;
  logic             b_rsp_valid, b_rsp_hit, b_bus_valid, b_bus_cmd;
  logic [IDX_W-1:0] a_bus_idx, b_bus_idx;

  // bench-injected snoop traffic, merged onto each agent's snoop port
  logic             inj_a = 0, inj_b = 0, inj_cmd = 0;
  logic [IDX_W-1:0] inj_idx = 0;

  logic             a_snp_valid, a_snp_cmd, b_snp_valid, b_snp_cmd;
  logic [IDX_W-1:0] a_snp_idx, b_snp_idx;

  assign a_snp_valid = b_bus_valid | inj_a;
  assign a_snp_cmd   = inj_a ? inj_cmd : b_bus_cmd;
  assign a_snp_idx   = inj_a ? inj_idx : b_bus_idx;
  assign b_snp_valid = a_bus_valid | inj_b;
  assign b_snp_cmd   = inj_b ? inj_cmd : a_bus_cmd;
  assign b_snp_idx   = inj_b ? inj_idx : a_bus_idx;

  vi_line_ctrl #(.LINES(LINES)) i_vi_line_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(a_req_valid), .req_op(a_req_op), .req_idx(a_req_idx),
    .snp_valid(a_snp_valid), .snp_cmd(a_snp_cmd), .snp_idx(a_snp_idx),
    .rsp_valid(a_rsp_valid), .rsp_hit(a_rsp_hit),
    .bus_valid(a_bus_valid), .bus_cmd(a_bus_cmd), .bus_idx(a_bus_idx)
  );

  vi_line_ctrl #(.LINES(LINES)) i_vi_line_ctrl_b (
    .clk(clk), .rst(rst),
    .req_valid(b_req_valid), .req_op(b_req_op), .req_idx(b_req_idx),
    .snp_valid(b_snp_valid), .snp_cmd(b_snp_cmd), .snp_idx(b_snp_idx),
    .rsp_valid(b_rsp_valid), .rsp_hit(b_rsp_hit),
    .bus_valid(b_bus_valid), .bus_cmd(b_bus_cmd), .bus_idx(b_bus_idx)
  );

  int total = 0;
  int bad   = 0;

  // sampled response of the last issued request
  logic             s_rv, s_hit, s_bv, s_bc;
  logic [IDX_W-1:0] s_bi;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // starts and ends at a falling edge; response sampled one edge later
  task automatic issue(input bit ag, input logic [1:0] op, input int idx);
    if (!ag) begin a_req_valid = 1; a_req_op = op; a_req_idx = IDX_W'(idx); end
    else     begin b_req_valid = 1; b_req_op = op; b_req_idx = IDX_W'(idx); end
    @(negedge clk);
    s_rv  = ag ? b_rsp_valid : a_rsp_valid;
    s_hit = ag ? b_rsp_hit   : a_rsp_hit;
    s_bv  = ag ? b_bus_valid : a_bus_valid;
    s_bc  = ag ? b_bus_cmd   : a_bus_cmd;
    s_bi  = ag ? b_bus_idx   : a_bus_idx;
    a_req_valid = 0;
    b_req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_rsp(input string tag, input bit hit, input bit bv, input bit bc, input int idx);
    check(s_rv == 1'b1, {tag, " rsp_valid"}, s_rv, 1);
    check(s_hit == hit, {tag, " hit"}, s_hit, hit);
    check(s_bv == bv, {tag, " bus_valid"}, s_bv, bv);
    if (bv) begin
      check(s_bc == bc, {tag, " bus_cmd"}, s_bc, bc);
      check(s_bi == IDX_W'(idx), {tag, " bus_idx"}, s_bi, idx);
    end
  endtask

  task automatic t_reset();
    check(!a_rsp_valid && !a_bus_valid, "R11 idle after reset", a_rsp_valid, 0);
    for (int i = 0; i < LINES; i += 5) begin
      issue(0, LD, i);
      expect_rsp("R1 first load misses", 0, 1, 0, i);
    end
  endtask

  task automatic t_load();
    issue(0, LD, 3); expect_rsp("R2 load miss", 0, 1, 0, 3);
    issue(0, LD, 3); expect_rsp("R3 load hit", 1, 0, 0, 3);
    idle(1);
    check(!a_rsp_valid && !a_bus_valid, "R11 no output without request", a_rsp_valid, 0);
  endtask

  task automatic t_store();
    issue(0, ST, 6); expect_rsp("R4 store on clear line", 0, 1, 1, 6);
    idle(1);
    issue(0, LD, 6); expect_rsp("R4 no allocate", 0, 1, 0, 6);
    idle(1);
    issue(0, ST, 3); expect_rsp("R5 store on set line", 1, 1, 1, 3);
    idle(1);
    issue(0, LD, 3); expect_rsp("R5 line stays set", 1, 0, 0, 3);
  endtask

  task automatic t_evict();
    issue(0, EV, 3); expect_rsp("R6 evict set line", 1, 0, 0, 3);
    issue(0, LD, 3); expect_rsp("R6 line cleared", 0, 1, 0, 3);
    idle(1);
    issue(0, EV, 7); expect_rsp("R6 evict clear line", 0, 0, 0, 7);
    issue(0, LD, 7); expect_rsp("R6 evict clear keeps clear", 0, 1, 0, 7);
    idle(1);
  endtask

  task automatic inject_b(input bit cmd, input int idx);
    inj_b = 1; inj_cmd = cmd; inj_idx = IDX_W'(idx);
    @(negedge clk);
    check(!b_rsp_valid && !b_bus_valid, "R8 snoop alone gives no output", b_rsp_valid, 0);
    inj_b = 0;
  endtask

  task automatic t_snoop();
    issue(1, LD, 9); idle(1);
    inject_b(1, 9);
    issue(1, LD, 9); expect_rsp("R7 foreign write clears line", 0, 1, 0, 9);
    idle(1);
    issue(1, LD, 10); idle(1);
    inject_b(0, 10);
    issue(1, LD, 10); expect_rsp("R8 foreign read ignored", 1, 0, 0, 10);
    inject_b(1, 11);
    issue(1, LD, 11); expect_rsp("R8 write to clear line ignored", 0, 1, 0, 11);
    idle(1);
  endtask

  task automatic t_collide();
    // B holds 12; A stores 12; B loads 12 in the cycle the write is snooped
    issue(1, LD, 12); idle(1);
    issue(0, ST, 12);
    issue(1, LD, 12); expect_rsp("R9 snoop before load", 0, 1, 0, 12);
    idle(1);
    issue(1, LD, 13); idle(1);
    issue(0, ST, 13);
    issue(1, ST, 13); expect_rsp("R9 snoop before store", 0, 1, 1, 13);
    idle(1);
    issue(1, LD, 13); expect_rsp("R9 colliding store leaves clear", 0, 1, 0, 13);
    idle(1);
  endtask

  task automatic t_diff_line();
    issue(1, LD, 14); issue(1, LD, 15); idle(1);
    inj_b = 1; inj_cmd = 1; inj_idx = 4'd14;
    b_req_valid = 1; b_req_op = LD; b_req_idx = 4'd15;
    @(negedge clk);
    check(b_rsp_valid && b_rsp_hit && !b_bus_valid, "R10 other line still hits", b_rsp_hit, 1);
    inj_b = 0; b_req_valid = 0;
    issue(1, LD, 14); expect_rsp("R10 snooped line cleared", 0, 1, 0, 14);
    idle(1);
  endtask

  task automatic t_coherence();
    for (int i = 0; i < LINES; i += 3) begin
      issue(0, LD, i); issue(1, LD, i); idle(2);
      issue(0, ST, i); idle(2);
      issue(1, LD, i);
      check(s_hit == 1'b0, "R12 B stale after A store", s_hit, 0);
      idle(2);
      issue(1, ST, i); idle(2);
      issue(0, LD, i);
      check(s_hit == 1'b0, "R12 A stale after B store", s_hit, 0);
      idle(2);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_load();
    t_store();
    t_evict();
    t_snoop();
    t_collide();
    t_diff_line();
    t_coherence();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule